// File: doc/BRIEF.md
# External Test Access Multiplexer for Program and Data Memories

This block lets a tester reach a set of on-chip single-port memories through one narrow pin interface. Five instruction memories hold the program: four are 32 bits wide and one is 14 bits wide, each with 128 entries. Ten data memories of 32 x 32 hold operands and results. A 4-bit select picks the target memory. A 7-bit address, a 32-bit write bus and a 32-bit read bus complete the pin interface. Two mode pins choose one of three phases. In the load phase the tester writes program and data. In the run phase the core owns the data memory enables. In the unload phase the tester reads back results.

In the run phase the select and address pins drive instruction issue. The addressed instruction word is fetched. A stub core then copies each fetched word into data memory 0, which stands in for the real datapath's write-back. The memory arrays are behavioural models.

Top module: `tmem_access_mux`

## Requirements
- R1: With `wr_pin`=1 and `ext_ctl`=1 (load), `wdata` is written at the clock edge into the memory chosen by `mem_sel`, at the entry chosen by `addr`.
- R2: With `wr_pin`=0 and `ext_ctl`=1 (unload), the selected data memory entry appears on `rdata` after the next clock edge. No memory is written in this mode.
- R3: After any clock edge where the mode was not unload, `rdata` is zero. `rdata` is also zero when an instruction memory (select 0 to 4) is chosen in unload mode.
- R4: Select map: values 0 to 3 are the wide instruction memories, 4 is the narrow instruction memory, and 5 to 14 are data memories 0 to 9. Value 15 selects nothing: a load writes no memory and an unload returns zero. At most one data memory is written per cycle.
- R5: Data memories use `addr[4:0]`. `addr[6:5]` is ignored for them.
- R6: A load to the narrow instruction memory stores only `wdata[13:0]`. A fetch from it returns that value zero-extended to 32 bits.
- R7: With `ext_ctl`=0 (run), select 0 to 4 fetches the addressed instruction word. At the following edge the stub core writes that word into data memory 0 at `addr[4:0]` of the fetch cycle, provided `ext_ctl` is still 0.
- R8: `wr_pin`=1 with `ext_ctl`=0 behaves as run mode. `wdata` is not written anywhere.
- R9: Setting `ext_ctl`=1 hands the data memory enables to the pins. A core write still pending from the previous run cycle is dropped.
- R10: While `rst_n` is low, `rdata` is zero and any pending core write is cleared. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_sel | input | 4 | Target memory select |
| addr | input | 7 | Entry address |
| wdata | input | 32 | Write data for load mode |
| wr_pin | input | 1 | Mode pin: write direction |
| ext_ctl | input | 1 | Mode pin: 1 = pins own data memory enables, 0 = core owns them |
| rdata | output | 32 | Registered read data in unload mode, zero otherwise |

## Verification
A wrong select decode or a stuck enable leaves its mark in memory contents, not on any output at once. Such a fault surfaces only at the first unload that reads the affected entry, which may be many cycles after the bad write. The stub core's copy path gives the run phase a visible trace in data memory 0. A fetch, zero-extension or handover fault therefore shows up two cycles after the run cycle, once that entry is unloaded. A fault in read-path gating shows up as nonzero `rdata` one cycle after any cycle that was not an unload.

// File: rtl/tmem_access_mux.sv
module tmem_access_mux #(
  parameter int SW      = 4,
  parameter int AW      = 7,
  parameter int DW      = 32,
  parameter int NWIDE   = 4,
  parameter int NBITS   = 14,
  parameter int IDEPTH  = 128,
  parameter int NDM     = 10,
  parameter int DDEPTH  = 32,
  parameter int CORE_DM = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] mem_sel,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_pin,
  input  logic          ext_ctl,
  output logic [DW-1:0] rdata
);
  localparam int NIM = NWIDE + 1;
  localparam int NMEM = NIM + NDM;
  localparam int IAW = $clog2(IDEPTH);
  localparam int DAW = $clog2(DDEPTH);
  localparam int WSW = $clog2(NWIDE);
  localparam int DIW = $clog2(NDM);

  logic load_m, unload_m, run_m;
  assign load_m   = wr_pin & ext_ctl;
  assign unload_m = !wr_pin & ext_ctl;
  assign run_m    = !ext_ctl;

  logic sel_wide, sel_nar, sel_dm;
  logic [DIW-1:0] dm_idx;
  assign sel_wide = int'(mem_sel) < NWIDE;
  assign sel_nar  = int'(mem_sel) == NWIDE;
  assign sel_dm   = int'(mem_sel) >= NIM && int'(mem_sel) < NMEM;
  assign dm_idx   = DIW'(int'(mem_sel) - NIM);

  logic [IAW-1:0] iaddr;
  logic [DAW-1:0] daddr;
  assign iaddr = IAW'(addr);
  assign daddr = addr[DAW-1:0];

  logic [NWIDE-1:0][DW-1:0] im_rd;
  logic [NBITS-1:0]         imn_rd;
  logic [NDM-1:0][DW-1:0]   dm_rd;

  for (genvar g = 0; g < NWIDE; g++) begin : g_imw
    logic [DW-1:0] mem [IDEPTH];
    always_ff @(posedge clk)
      if (load_m && int'(mem_sel) == g) mem[iaddr] <= wdata;
    assign im_rd[g] = mem[iaddr];
  end

  logic [NBITS-1:0] imn [IDEPTH];
  always_ff @(posedge clk)
    if (load_m && sel_nar) imn[iaddr] <= wdata[NBITS-1:0];
  assign imn_rd = imn[iaddr];

  // stub core: fetch, then copy the word into one data memory
  logic          core_pend;
  logic [DW-1:0] fword;
  logic [DAW-1:0] pend_addr;
  always_ff @(posedge clk) begin
    if (!rst_n) core_pend <= 1'b0;
    else        core_pend <= run_m && (sel_wide || sel_nar);
    if (run_m) begin
      fword     <= sel_nar ? DW'(imn_rd) : im_rd[mem_sel[WSW-1:0]];
      pend_addr <= daddr;
    end
  end

  logic core_we;
  assign core_we = core_pend && run_m && rst_n;

  logic [NDM-1:0] dm_we;
  logic [DAW-1:0] dm_wa;
  logic [DW-1:0]  dm_wd;
  assign dm_wa = ext_ctl ? daddr : pend_addr;
  assign dm_wd = ext_ctl ? wdata : fword;
  always_comb begin
    dm_we = '0;
    if (ext_ctl) begin
      if (load_m && sel_dm) dm_we[dm_idx] = 1'b1;
    end else if (core_we) begin
      dm_we[CORE_DM] = 1'b1;
    end
  end

  for (genvar g = 0; g < NDM; g++) begin : g_dm
    logic [DW-1:0] mem [DDEPTH];
    always_ff @(posedge clk)
      if (dm_we[g]) mem[dm_wa] <= dm_wd;
    assign dm_rd[g] = mem[daddr];
  end

  always_ff @(posedge clk)
    if (!rst_n) rdata <= '0;
    else        rdata <= (unload_m && sel_dm) ? dm_rd[dm_idx] : '0;

  // R3
  rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unload_m |=> rdata == '0);
  // R2
  unload_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unload_m |-> dm_we == '0);
  // R4
  dm_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dm_we));
  // R4
  sel_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unload_m && int'(mem_sel) >= NMEM) |=> rdata == '0);
  // R10
  rst_out_chk: assert property (@(posedge clk)
    !rst_n |=> rdata == '0);
endmodule

// File: tb/tb_tmem_access_mux.sv
module tb_tmem_access_mux;
  logic clk = 0, rst_n = 0;
  logic [3:0] mem_sel = 4'd15;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic wr_pin = 0, ext_ctl = 0;
  logic [31:0] rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmem_access_mux dut (.clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .addr(addr),
    .wdata(wdata), .wr_pin(wr_pin), .ext_ctl(ext_ctl), .rdata(rdata));

  // {wr_pin, ext_ctl, mem_sel, addr, wdata, expected rdata}
  localparam int NV = 28;
  localparam logic [76:0] VEC [NV] = '{
    {2'b11, 4'd5,  7'h00, 32'h11111111, 32'h0},
    {2'b11, 4'd6,  7'h00, 32'h22222222, 32'h0},
    {2'b11, 4'd14, 7'h1F, 32'hEEEE0001, 32'h0},
    {2'b11, 4'd5,  7'h09, 32'h00000099, 32'h0},
    {2'b01, 4'd5,  7'h00, 32'h0,        32'h11111111},
    {2'b01, 4'd6,  7'h00, 32'h0,        32'h22222222},
    {2'b01, 4'd14, 7'h1F, 32'h0,        32'hEEEE0001},
    {2'b01, 4'd14, 7'h7F, 32'h0,        32'hEEEE0001},
    {2'b11, 4'd0,  7'h03, 32'hCAFE0003, 32'h0},
    {2'b00, 4'd0,  7'h03, 32'h0,        32'h0},
    {2'b00, 4'd15, 7'h00, 32'h0,        32'h0},
    {2'b01, 4'd5,  7'h03, 32'h0,        32'hCAFE0003},
    {2'b11, 4'd4,  7'h07, 32'hFFFFABCD, 32'h0},
    {2'b00, 4'd4,  7'h07, 32'h0,        32'h0},
    {2'b00, 4'd15, 7'h00, 32'h0,        32'h0},
    {2'b01, 4'd5,  7'h07, 32'h0,        32'h00002BCD},
    {2'b10, 4'd5,  7'h09, 32'hDEAD0009, 32'h0},
    {2'b01, 4'd5,  7'h09, 32'h0,        32'h00000099},
    {2'b11, 4'd1,  7'h09, 32'h55550009, 32'h0},
    {2'b00, 4'd1,  7'h09, 32'h0,        32'h0},
    {2'b11, 4'd6,  7'h01, 32'h77777777, 32'h0},
    {2'b01, 4'd5,  7'h09, 32'h0,        32'h00000099},
    {2'b01, 4'd6,  7'h01, 32'h0,        32'h77777777},
    {2'b01, 4'd2,  7'h03, 32'h0,        32'h0},
    {2'b01, 4'd15, 7'h00, 32'h0,        32'h0},
    {2'b11, 4'd15, 7'h00, 32'h0BADBEEF, 32'h0},
    {2'b01, 4'd5,  7'h00, 32'h0,        32'h11111111},
    {2'b01, 4'd6,  7'h00, 32'h0,        32'h22222222}
  };
  localparam string TAG [NV] = '{"R1","R1","R4","R1","R2","R4","R4","R5",
    "R3","R7","R7","R7","R6","R6","R6","R6","R8","R8",
    "R9","R9","R9","R9","R9","R3","R4","R4","R4","R4"};

  task automatic check(input string req, input logic [31:0] exp);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  task automatic drive(input logic w, input logic c, input logic [3:0] s,
                       input logic [6:0] a, input logic [31:0] d);
    wr_pin = w; ext_ctl = c; mem_sel = s; addr = a; wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", 32'h0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][76], VEC[i][75], VEC[i][74:71], VEC[i][70:64], VEC[i][63:32]);
      @(negedge clk);
      check(TAG[i], VEC[i][31:0]);
    end
    // R10: reset forces rdata to zero even during an unload
    drive(1'b0, 1'b1, 4'd5, 7'h00, 32'h0);
    rst_n = 0;
    @(negedge clk);
    check("R10", 32'h0);
    // R10: reset drops a pending core copy (would write 55550009 to entry 9)
    rst_n = 1;
    drive(1'b0, 1'b0, 4'd1, 7'h09, 32'h0);
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    drive(1'b0, 1'b1, 4'd5, 7'h09, 32'h0);
    @(negedge clk);
    check("R10", 32'h00000099);
    // R7: without reset the same run does copy the word
    drive(1'b0, 1'b0, 4'd1, 7'h09, 32'h0);
    @(negedge clk);
    drive(1'b0, 1'b0, 4'd15, 7'h00, 32'h0);
    @(negedge clk);
    drive(1'b0, 1'b1, 4'd5, 7'h09, 32'h0);
    @(negedge clk);
    check("R7", 32'h55550009);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: rdata=%h expected=completion", rdata);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule